// File: doc/BRIEF.md
# Card Reset and Reference-Clock Enable Sequencer

This block drives the two sideband signals an expansion-card slot needs once its power is up. One is an active-low card reset, `card_perst_n`. The other is an enable for the card's reference clock, `refclk_en`. It watches these inputs:

- a power-good flag for each card rail;
- the host's active-low reset request;
- two active-low presence detects, one for a PCI Express card and one for a USB-only card;
- a chip enable.

Every input passes through a synchronizer of `SYNC_STAGES` flops before the control state machine sees it.

The clock enable follows the power and presence qualification with no added wait. The reset is released only after the full qualification has held for a programmable number of clock ticks. That number is clamped to a window derived from nanosecond parameters, which by default is 4 ms to 20 ms. Removing the card, losing a rail or dropping the enable pulls reset low again within a bounded time. The host request can pull reset low on its own without touching the clock enable.

The state machine has five states:

| State | refclk_en | card_perst_n | Meaning |
|---|---|---|---|
| `ST_EMPTY` | low | low | Slot unqualified |
| `ST_USB_ONLY` | low | low | Only the USB detect is active |
| `ST_HOLD` | high | low | Clock qualified, host holds reset |
| `ST_WAIT` | high | low | Delay counter running |
| `ST_RUN` | high | high | Reset released |

Its transitions are:

- **Qualify.** `ST_EMPTY`/`ST_USB_ONLY` go to `ST_WAIT` or to `ST_HOLD`, depending on the host request.
- **Host go.** `ST_HOLD` goes to `ST_WAIT`.
- **Delay done.** `ST_WAIT` goes to `ST_RUN`.
- **Host stop.** `ST_WAIT`/`ST_RUN` go to `ST_HOLD`.
- **Drop.** Any state goes to `ST_EMPTY` or `ST_USB_ONLY` when a rail, the card or the enable is lost.

Top module: `card_rst_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, both `card_perst_n` and `refclk_en` are low.
- R2: `refclk_en` rises exactly `SYNC_STAGES+1` clock edges after these conditions all hold: every bit of `pg_ok` is 1, `pcie_det_n` is 0 and `chip_en` is 1. The level of `host_rst_req_n` has no effect on it.
- R3: `card_perst_n` goes high only while `refclk_en` is high and `host_rst_req_n` is 1. The release comes `SYNC_STAGES+1+D` edges after the full qualification starts, where D is the effective delay in ticks.
- R4: D equals `dly_ticks` clamped to [ceil(DLY_MIN_NS/CLK_PERIOD_NS), floor(DLY_MAX_NS/CLK_PERIOD_NS)]. With a 4 ns clock, 40 ns and 200 ns give a window of 10 to 50 ticks.
- R5: If the full qualification drops for any number of cycles before the delay completes, the count restarts from zero. A later release again needs D full ticks.
- R6: `host_rst_req_n` going low drives `card_perst_n` low `SYNC_STAGES+1` edges later, while `refclk_en` stays high.
- R7: Card removal, a rail's power-good going low, or `chip_en` going low drives both outputs low `SYNC_STAGES+1` edges later. This is within `FAST_BOUND_NS` (500 ns).
- R8: With `pcie_det_n` high, neither output ever goes high, whatever `usb_det_n`, the rails and the host request do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, period `CLK_PERIOD_NS` |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_ok | input | N_RAILS | Power-good flag per card rail; bit 1 means good |
| host_rst_req_n | input | 1 | Host reset request, active low |
| pcie_det_n | input | 1 | PCI Express card presence, active low |
| usb_det_n | input | 1 | USB card presence, active low |
| chip_en | input | 1 | Block enable, active high |
| dly_ticks | input | DLY_W | Requested release delay in clock ticks |
| card_perst_n | output | 1 | Card reset, active low |
| refclk_en | output | 1 | Reference-clock enable, active high |

## Verification
Every result is delayed by the synchronizer depth plus the state register. With two stages, a change driven before edge n shows on `refclk_en`, and as a reset assertion, right after edge n+2. A reset release shows right after edge n+2+D. The bench's reference model pushes the pins into a two-deep history and applies the rules to the oldest entry. It keeps a running count of fully qualified cycles and compares both outputs one nanosecond after every rising edge. The timing checks count rising edges from the drive point until the output moves, and expect exactly 3 or D+3.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [2:0] {
        ST_EMPTY    = 3'd0,
        ST_USB_ONLY = 3'd1,
        ST_HOLD     = 3'd2,
        ST_WAIT     = 3'd3,
        ST_RUN      = 3'd4
    } crs_state_e;

endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
    parameter int              W       = 7,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/crs_dly_cnt.sv
module crs_dly_cnt #(
    parameter int          DLY_W     = 24,
    parameter int unsigned MIN_TICKS = 1,
    parameter int unsigned MAX_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DLY_W-1:0] dly_ticks,
    output logic             done
);

    // A zero-tick window would never finish; keep at least one tick.
    localparam int unsigned LO_TICKS = (MIN_TICKS < 1) ? 1 : MIN_TICKS;
    localparam int unsigned HI_TICKS = (MAX_TICKS < LO_TICKS) ? LO_TICKS : MAX_TICKS;
    localparam logic [DLY_W-1:0] LO = DLY_W'(LO_TICKS);
    localparam logic [DLY_W-1:0] HI = DLY_W'(HI_TICKS);

    logic [DLY_W-1:0] eff;
    logic [DLY_W-1:0] cnt;

    always_comb begin
        if (dly_ticks < LO)      eff = LO;
        else if (dly_ticks > HI) eff = HI;
        else                     eff = dly_ticks;
    end

    assign done = run && (cnt >= eff - DLY_W'(1));

    // The count is cleared whenever the machine is outside its wait state,
    // so any break in qualification restarts the delay.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (!run)  cnt <= '0;
        else if (!done) cnt <= cnt + DLY_W'(1);
    end

endmodule

// File: rtl/crs_fsm.sv
module crs_fsm
    import crs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rails_ok,
    input  logic card_pcie,
    input  logic card_usb,
    input  logic host_go,
    input  logic enabled,
    input  logic dly_done,
    output logic cnt_run,
    output logic perst_n,
    output logic refclk_on
);

    crs_state_e state_q;
    crs_state_e state_d;
    crs_state_e idle_pick;
    logic       clk_qual;

    assign clk_qual  = rails_ok && card_pcie && enabled;
    assign idle_pick = (card_usb && !card_pcie) ? ST_USB_ONLY : ST_EMPTY;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY, ST_USB_ONLY: begin
                if (clk_qual) state_d = host_go ? ST_WAIT : ST_HOLD;
                else          state_d = idle_pick;
            end
            ST_HOLD: begin
                if (!clk_qual)    state_d = idle_pick;
                else if (host_go) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!clk_qual)     state_d = idle_pick;
                else if (!host_go) state_d = ST_HOLD;
                else if (dly_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!clk_qual)     state_d = idle_pick;
                else if (!host_go) state_d = ST_HOLD;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perst_n   <= 1'b0;
            refclk_on <= 1'b0;
        end else begin
            perst_n   <= (state_d == ST_RUN);
            refclk_on <= (state_d == ST_HOLD) || (state_d == ST_WAIT) ||
                         (state_d == ST_RUN);
        end
    end

    assign cnt_run = (state_q == ST_WAIT);

endmodule

// File: rtl/card_rst_seq.sv
module card_rst_seq #(
    parameter int N_RAILS       = 3,
    parameter int CLK_PERIOD_NS = 4,
    parameter int DLY_MIN_NS    = 4_000_000,
    parameter int DLY_MAX_NS    = 20_000_000,
    parameter int DLY_W         = 24,
    parameter int SYNC_STAGES   = 2,
    parameter int FAST_BOUND_NS = 500
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RAILS-1:0] pg_ok,
    input  logic               host_rst_req_n,
    input  logic               pcie_det_n,
    input  logic               usb_det_n,
    input  logic               chip_en,
    input  logic [DLY_W-1:0]   dly_ticks,
    output logic               card_perst_n,
    output logic               refclk_en
);

    localparam int unsigned MIN_TICKS = (DLY_MIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int unsigned MAX_TICKS = DLY_MAX_NS / CLK_PERIOD_NS;
    localparam int          SV_W      = N_RAILS + 4;
    localparam int          B_EN      = N_RAILS;
    localparam int          B_HOST    = N_RAILS + 1;
    localparam int          B_PCIE    = N_RAILS + 2;
    localparam int          B_USB     = N_RAILS + 3;
    // Inactive view: both detects absent, host holding reset, block disabled.
    localparam logic [SV_W-1:0] SV_IDLE = {2'b11, 2'b00, {N_RAILS{1'b0}}};

    logic [SV_W-1:0] raw_v;
    logic [SV_W-1:0] syn_v;
    logic            cnt_run;
    logic            dly_done;

    assign raw_v = {usb_det_n, pcie_det_n, host_rst_req_n, chip_en, pg_ok};

    crs_sync #(
        .W       (SV_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SV_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_v),
        .dout  (syn_v)
    );

    crs_dly_cnt #(
        .DLY_W     (DLY_W),
        .MIN_TICKS (MIN_TICKS),
        .MAX_TICKS (MAX_TICKS)
    ) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (cnt_run),
        .dly_ticks (dly_ticks),
        .done      (dly_done)
    );

    crs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rails_ok  (&syn_v[N_RAILS-1:0]),
        .card_pcie (!syn_v[B_PCIE]),
        .card_usb  (!syn_v[B_USB]),
        .host_go   (syn_v[B_HOST]),
        .enabled   (syn_v[B_EN]),
        .dly_done  (dly_done),
        .cnt_run   (cnt_run),
        .perst_n   (card_perst_n),
        .refclk_on (refclk_en)
    );

endmodule

// File: rtl/crs_chk.sv
module crs_chk #(
    parameter int N_RAILS       = 3,
    parameter int SYNC_STAGES   = 2,
    parameter int MIN_TICKS     = 1,
    parameter int FAST_CYC      = 125
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_RAILS-1:0] pg_ok,
    input logic               host_rst_req_n,
    input logic               pcie_det_n,
    input logic               chip_en,
    input logic               card_perst_n,
    input logic               refclk_en
);

    localparam int SAT = SYNC_STAGES + 2;

    logic qual_raw;
    int   drop_age;
    int   absent_cnt;
    int   host_low_cnt;
    int   on_cnt;

    assign qual_raw = (&pg_ok) && !pcie_det_n && chip_en && host_rst_req_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drop_age     <= 0;
            absent_cnt   <= 0;
            host_low_cnt <= 0;
            on_cnt       <= 0;
        end else begin
            drop_age     <= (qual_raw || !card_perst_n) ? 0 :
                            ((drop_age < FAST_CYC + 1) ? drop_age + 1 : drop_age);
            absent_cnt   <= !pcie_det_n ? 0 :
                            ((absent_cnt < SAT) ? absent_cnt + 1 : absent_cnt);
            host_low_cnt <= host_rst_req_n ? 0 :
                            ((host_low_cnt < SAT) ? host_low_cnt + 1 : host_low_cnt);
            on_cnt       <= !refclk_en ? 0 :
                            ((on_cnt < MIN_TICKS) ? on_cnt + 1 : on_cnt);
        end
    end

    AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!card_perst_n && !refclk_en)); // R1

    AST_RELEASE_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        card_perst_n |-> refclk_en); // R3

    AST_MIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_perst_n) |-> (on_cnt >= MIN_TICKS)); // R4

    AST_HOST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_low_cnt > SYNC_STAGES) |-> !card_perst_n); // R6

    AST_FAST_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        drop_age <= FAST_CYC); // R7

    AST_USB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (absent_cnt > SYNC_STAGES) |-> (!card_perst_n && !refclk_en)); // R8

endmodule

bind card_rst_seq crs_chk #(
    .N_RAILS     (N_RAILS),
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_TICKS   (int'(MIN_TICKS)),
    .FAST_CYC    (FAST_BOUND_NS / CLK_PERIOD_NS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pg_ok          (pg_ok),
    .host_rst_req_n (host_rst_req_n),
    .pcie_det_n     (pcie_det_n),
    .chip_en        (chip_en),
    .card_perst_n   (card_perst_n),
    .refclk_en      (refclk_en)
);

// File: tb/sim_card_rst_seq.sv
`timescale 1ns/1ps
module sim_card_rst_seq;

    localparam int LO_T = 10;   // R4 window with 4 ns clock, 40 ns / 200 ns
    localparam int HI_T = 50;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  pg_ok;
    logic        host_n, pcie_n, usb_n, en;
    logic [23:0] dly;
    logic        perst_n, refclk;

    int total = 0;
    int bad = 0;
    bit done_flag = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    card_rst_seq #(
        .N_RAILS(3), .CLK_PERIOD_NS(4), .DLY_MIN_NS(40), .DLY_MAX_NS(200),
        .DLY_W(24), .SYNC_STAGES(2), .FAST_BOUND_NS(500)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pg_ok(pg_ok), .host_rst_req_n(host_n),
        .pcie_det_n(pcie_n), .usb_det_n(usb_n), .chip_en(en),
        .dly_ticks(dly), .card_perst_n(perst_n), .refclk_en(refclk)
    );

    // Reference model: two-deep input history, streak of qualified cycles.
    logic [6:0] s1, s2, use_v;
    int   streak;
    logic e_clk, e_rst;
    localparam logic [6:0] INACT = 7'b1100000;

    function automatic int deff(input logic [23:0] d);
        if (d < LO_T) return LO_T;
        if (d > HI_T) return HI_T;
        return int'(d);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic cq;
        if (!rst_n) begin
            s1 = INACT; s2 = INACT; streak = 0; e_clk = 0; e_rst = 0;
        end else begin
            use_v = s2;
            s2 = s1;
            s1 = {usb_n, pcie_n, host_n, en, pg_ok};
            cq = (&use_v[2:0]) & use_v[3] & ~use_v[5];
            streak = (cq & use_v[4]) ? streak + 1 : 0;
            e_clk = cq;
            e_rst = (streak > deff(dly));
        end
        #1;
        if (!done_flag) begin
            chk(refclk === e_clk, cur_req, "refclk_en", int'(refclk), int'(e_clk));
            chk(perst_n === e_rst, cur_req, "card_perst_n", int'(perst_n), int'(e_rst));
        end
    end

    // Counts rising edges from the drive point until the signal reaches level.
    task automatic edges_until(input bit sel_clk, input bit level, output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (((sel_clk ? refclk : perst_n) !== level) && n < 200);
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20000 * 4);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        int n;
        rst_n = 0; pg_ok = 3'b000; host_n = 0; pcie_n = 1; usb_n = 1; en = 0; dly = 24'd20;
        idle(4);
        chk(perst_n === 1'b0 && refclk === 1'b0, "R1", "outputs in reset", int'({perst_n, refclk}), 0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        chk(perst_n === 1'b0 && refclk === 1'b0, "R1", "outputs after reset", int'({perst_n, refclk}), 0);

        // R3: full qualification, release after D+3 edges
        cur_req = "R3";
        @(negedge clk); pg_ok = 3'b111; pcie_n = 0; en = 1; host_n = 1;
        edges_until(1'b0, 1'b1, n);
        chk(n == 23, "R3", "release edges D=20", n, 23);
        chk(refclk === 1'b1, "R2", "clock on while released", int'(refclk), 1);

        // R6: host request low holds reset, clock stays
        cur_req = "R6";
        @(negedge clk); host_n = 0;
        edges_until(1'b0, 1'b0, n);
        chk(n == 3, "R6", "assert edges after host low", n, 3);
        chk(refclk === 1'b1, "R6", "clock kept during host reset", int'(refclk), 1);
        idle(5);

        // R5: break during the wait restarts the count
        cur_req = "R5";
        @(negedge clk); host_n = 1;
        idle(8);
        host_n = 0;
        idle(2);
        host_n = 1;
        edges_until(1'b0, 1'b1, n);
        chk(n == 23, "R5", "release edges after restart", n, 23);

        // R4: clamp low and high
        cur_req = "R4";
        @(negedge clk); host_n = 0; idle(5);
        dly = 24'd3; host_n = 1;
        edges_until(1'b0, 1'b1, n);
        chk(n == LO_T + 3, "R4", "release edges clamped low", n, LO_T + 3);
        @(negedge clk); host_n = 0; idle(5);
        dly = 24'd200; host_n = 1;
        edges_until(1'b0, 1'b1, n);
        chk(n == HI_T + 3, "R4", "release edges clamped high", n, HI_T + 3);
        @(negedge clk); dly = 24'd20;

        // R2: clock follows qualification regardless of host request
        cur_req = "R2";
        @(negedge clk); host_n = 0; pcie_n = 1; idle(6);
        pcie_n = 0;
        edges_until(1'b1, 1'b1, n);
        chk(n == 3, "R2", "clock enable edges", n, 3);
        idle(40);
        chk(perst_n === 1'b0, "R2", "reset held with host low", int'(perst_n), 0);

        // R7: each drop cause asserts reset in three edges
        cur_req = "R7";
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); host_n = 1; pg_ok = 3'b111; pcie_n = 0; en = 1;
            idle(30);
            chk(perst_n === 1'b1, "R7", "released before drop", int'(perst_n), 1);
            if (k < 3) pg_ok[k] = 1'b0;
            else if (k == 3) pcie_n = 1'b1;
            else en = 1'b0;
            edges_until(1'b0, 1'b0, n);
            chk(n == 3 && n * 4 <= 500, "R7", "fast assert edges", n, 3);
            chk(refclk === 1'b0, "R7", "clock off after drop", int'(refclk), 0);
        end

        // R8: USB-only card never enables anything
        cur_req = "R8";
        @(negedge clk); pg_ok = 3'b111; en = 1; host_n = 1; pcie_n = 1; usb_n = 0;
        idle(100);
        chk(perst_n === 1'b0 && refclk === 1'b0, "R8", "usb-only outputs", int'({perst_n, refclk}), 0);
        @(negedge clk); pcie_n = 0;
        idle(30);
        chk(perst_n === 1'b1, "R8", "both present acts as pcie", int'(perst_n), 1);

        // R1: reset mid-operation
        cur_req = "R1";
        @(negedge clk); rst_n = 0;
        #1;
        chk(perst_n === 1'b0 && refclk === 1'b0, "R1", "async reset", int'({perst_n, refclk}), 0);
        idle(3);
        finish_run();
    end

endmodule